// File: doc/BRIEF.md
# Single-Cycle Six-Instruction 32-bit Processor Core

This core runs one instruction per clock from a small fixed set of six: two register-to-register arithmetic operations, an OR with a 16-bit literal, a word load, a word store and a conditional branch on register equality. In each cycle the core presents its program counter on the fetch port and decodes the returned word. It reads two source registers, forms a result or an effective address in the ALU and, on the next rising edge, commits the register write, the memory write and the new program counter together.

The surrounding system supplies both memories. Instruction fetch is a plain address-out, word-in port. The data port carries an address, write data and a write strobe, and returns read data combinationally within the same cycle. The core contains the program counter, a 32-entry register file with two read ports and one write port, the instruction decoder, the ALU and the branch-target adder.

Top module: `lite_core`

## Requirements
- R1: Reset is synchronous and active high. After any rising edge with `rst` high, `imem_addr` is 0. While `rst` is high, `dmem_we` stays low even when the fetched word is a store, and no register is written.
- R2: A word with opcode (bits 31:26) 0x00 and function code (bits 5:0) 0x21 writes the sum modulo 2^32 of the registers named by bits 25:21 and 20:16 into the register named by bits 15:11. The PC then advances by 4.
- R3: Opcode 0x00 with function code 0x23 writes (bits 25:21 register) minus (bits 20:16 register), modulo 2^32, into the register named by bits 15:11. The PC then advances by 4.
- R4: Opcode 0x0D writes the bits 25:21 register ORed with the zero-extended literal in bits 15:0 into the register named by bits 20:16.
- R5: Opcode 0x23 drives `dmem_addr` with the bits 25:21 register plus the sign-extended bits 15:0. It writes `dmem_rdata` into the register named by bits 20:16.
- R6: Opcode 0x2B raises `dmem_we`, drives the same address as R5 and puts the bits 20:16 register on `dmem_wdata`. It writes no register. No other opcode raises `dmem_we`.
- R7: Opcode 0x04 sets the PC to PC+4 plus the sign-extended bits 15:0 shifted left by two when its two source registers are equal. Otherwise the PC becomes PC+4. Negative offsets are included.
- R8: Register 0 always reads as zero, and writes that name it are dropped.
- R9: Any other opcode, and opcode 0x00 with any function code other than 0x21 or 0x23, writes neither a register nor memory and advances the PC by 4.
- R10: An instruction that names the same register as source and destination uses the value from before the edge. The new value is visible to the next instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Program counter, byte address of the fetched word |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data byte address (ALU result) |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Data write strobe, taken at the rising edge |
| dmem_rdata | input | 32 | Combinational read data at `dmem_addr` |

## Verification
The core holds almost all of its state in the register file, and that state never reaches a port directly. A corrupted register shows up only when a later store puts it on `dmem_wdata`, when a load or store uses it as a base on `dmem_addr`, or when a branch compares it and sends `imem_addr` elsewhere. A fault can therefore stay hidden for many cycles. A faulty program counter or write strobe, by contrast, is visible at the ports in the very next cycle. For this reason a cycle-by-cycle reference model compares the fetch address and every data-port transaction on each instruction, over long mixed instruction streams with few registers in use. This catches a bad register value at its first use.

// File: rtl/lite_core_pkg.sv
package lite_core_pkg;

    localparam int WORD_W   = 32;
    localparam int FIELD_W  = 5;
    localparam int OPC_W    = 6;
    localparam int IMM_W    = 16;

    localparam logic [OPC_W-1:0] OPC_RFMT  = 6'h00;
    localparam logic [OPC_W-1:0] OPC_ORIMM = 6'h0D;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_BREQ  = 6'h04;
    localparam logic [OPC_W-1:0] FN_ADD    = 6'h21;
    localparam logic [OPC_W-1:0] FN_SUB    = 6'h23;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    // Instruction word viewed in register format; bits 15:0 double as the literal.
    typedef struct packed {
        logic [OPC_W-1:0]   opcode;
        logic [FIELD_W-1:0] src_a;
        logic [FIELD_W-1:0] src_b;
        logic [FIELD_W-1:0] dst;
        logic [FIELD_W-1:0] shift;
        logic [OPC_W-1:0]   fn;
    } iword_t;

    typedef struct packed {
        logic    reg_we;
        logic    dst_from_rd;
        logic    b_from_imm;
        logic    imm_zero;
        logic    mem_we;
        logic    wb_from_mem;
        logic    is_branch;
        alu_op_e alu_op;
    } ctrl_t;

    function automatic logic [WORD_W-1:0] widen_imm(input logic [IMM_W-1:0] imm,
                                                    input logic zero_fill);
        return zero_fill ? {{(WORD_W-IMM_W){1'b0}}, imm}
                         : {{(WORD_W-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction

    function automatic logic [WORD_W-1:0] branch_disp(input logic [IMM_W-1:0] imm);
        return {{(WORD_W-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
    endfunction

endpackage

// File: rtl/lite_core_decode.sv
module lite_core_decode
    import lite_core_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [OPC_W-1:0] fn,
    output ctrl_t            ctrl
);

    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        case (opcode)
            OPC_RFMT: begin
                case (fn)
                    FN_ADD: begin
                        ctrl.reg_we      = 1'b1;
                        ctrl.dst_from_rd = 1'b1;
                        ctrl.alu_op      = ALU_ADD;
                    end
                    FN_SUB: begin
                        ctrl.reg_we      = 1'b1;
                        ctrl.dst_from_rd = 1'b1;
                        ctrl.alu_op      = ALU_SUB;
                    end
                    default: ;
                endcase
            end
            OPC_ORIMM: begin
                ctrl.reg_we     = 1'b1;
                ctrl.b_from_imm = 1'b1;
                ctrl.imm_zero   = 1'b1;
                ctrl.alu_op     = ALU_OR;
            end
            OPC_LOAD: begin
                ctrl.reg_we      = 1'b1;
                ctrl.b_from_imm  = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OPC_STORE: begin
                ctrl.mem_we     = 1'b1;
                ctrl.b_from_imm = 1'b1;
            end
            OPC_BREQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lite_core_alu.sv
module lite_core_alu
    import lite_core_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] res,
    output logic         zero
);

    logic lt;
    assign lt = $signed(a) < $signed(b);

    always_comb begin
        case (op)
            ALU_AND: res = a & b;
            ALU_OR:  res = a | b;
            ALU_ADD: res = a + b;
            ALU_SUB: res = a - b;
            ALU_SLT: res = {{(W-1){1'b0}}, lt};
            default: res = '0;
        endcase
    end

    assign zero = (res == '0);

endmodule

// File: rtl/lite_core_regs.sv
module lite_core_regs #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_idx,
    input  logic [W-1:0]          wr_data,
    input  logic [NRD-1:0][AW-1:0] rd_idx,
    output logic [NRD-1:0][W-1:0]  rd_data
);

    logic [W-1:0] store_q [DEPTH];

    // Entry 0 is never written; its reads are forced to zero below.
    always_ff @(posedge clk) begin
        if (wr_en && (wr_idx != '0)) begin
            store_q[wr_idx] <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = (rd_idx[p] == '0) ? '0 : store_q[rd_idx[p]];
    end

endmodule

// File: rtl/lite_core_pc.sv
module lite_core_pc #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         take,
    input  logic [W-1:0] disp,
    output logic [W-1:0] pc
);

    logic [W-1:0] seq;
    logic [W-1:0] target;

    assign seq    = pc + W'(4);
    assign target = seq + disp;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else begin
            pc <= take ? target : seq;
        end
    end

endmodule

// File: rtl/lite_core.sv
module lite_core
    import lite_core_pkg::*;
#(
    parameter int NUM_REGS = 32
) (
    input  logic              clk,
    input  logic              rst,
    output logic [WORD_W-1:0] imem_addr,
    input  logic [WORD_W-1:0] imem_rdata,
    output logic [WORD_W-1:0] dmem_addr,
    output logic [WORD_W-1:0] dmem_wdata,
    output logic              dmem_we,
    input  logic [WORD_W-1:0] dmem_rdata
);

    localparam int AW = $clog2(NUM_REGS);

    iword_t                  ins;
    ctrl_t                   ctrl;
    logic [IMM_W-1:0]        imm16;
    logic [1:0][AW-1:0]      rd_idx;
    logic [1:0][WORD_W-1:0]  rd_data;
    logic [WORD_W-1:0]       rs_val;
    logic [WORD_W-1:0]       rt_val;
    logic [WORD_W-1:0]       imm_ext;
    logic [WORD_W-1:0]       alu_b;
    logic [WORD_W-1:0]       alu_res;
    logic                    alu_zero;
    logic                    take;
    logic                    rf_we;
    logic [AW-1:0]           rf_widx;
    logic [WORD_W-1:0]       rf_wdata;
    logic [WORD_W-1:0]       pc;

    assign ins   = iword_t'(imem_rdata);
    assign imm16 = {ins.dst, ins.shift, ins.fn};

    lite_core_decode u_decode (
        .opcode (ins.opcode),
        .fn     (ins.fn),
        .ctrl   (ctrl)
    );

    assign rd_idx[0] = AW'(ins.src_a);
    assign rd_idx[1] = AW'(ins.src_b);

    lite_core_regs #(
        .W     (WORD_W),
        .DEPTH (NUM_REGS),
        .NRD   (2)
    ) u_regs (
        .clk     (clk),
        .wr_en   (rf_we),
        .wr_idx  (rf_widx),
        .wr_data (rf_wdata),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    assign rs_val  = rd_data[0];
    assign rt_val  = rd_data[1];
    assign imm_ext = widen_imm(imm16, ctrl.imm_zero);
    assign alu_b   = ctrl.b_from_imm ? imm_ext : rt_val;

    lite_core_alu #(.W(WORD_W)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .res  (alu_res),
        .zero (alu_zero)
    );

    assign take = ctrl.is_branch & alu_zero;

    lite_core_pc #(.W(WORD_W)) u_pc (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .disp (branch_disp(imm16)),
        .pc   (pc)
    );

    // Write-back: all commits happen on the same edge and are blocked in reset.
    assign rf_we    = ctrl.reg_we & ~rst;
    assign rf_widx  = ctrl.dst_from_rd ? AW'(ins.dst) : AW'(ins.src_b);
    assign rf_wdata = ctrl.wb_from_mem ? dmem_rdata : alu_res;

    assign imem_addr  = pc;
    assign dmem_addr  = alu_res;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_we & ~rst;

endmodule

// File: rtl/lite_core_checker.sv
module lite_core_checker
    import lite_core_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] imem_addr,
    input logic [WORD_W-1:0] imem_rdata,
    input logic              dmem_we,
    input logic [WORD_W-1:0] dmem_wdata,
    input logic [WORD_W-1:0] rs_val,
    input logic [WORD_W-1:0] rt_val
);

    logic rst_q = 1'b0;

    always_ff @(posedge clk) begin
        // R1: an edge taken in reset leaves the PC at zero
        if (rst_q) begin
            a_r1_pc_cleared: assert (imem_addr == '0)
                else $error("R1 PC not cleared after reset edge");
        end
        // R1: no data write while reset is high
        if (rst) begin
            a_r1_store_blocked: assert (!dmem_we)
                else $error("R1 store strobe during reset");
        end
        rst_q <= rst;
    end

    a_r9_pc_sequential: assert property (@(posedge clk) disable iff (rst)
        (imem_rdata[31:26] != OPC_BREQ) |=> (imem_addr == $past(imem_addr) + 32'd4))
        else $error("R9 PC did not advance by 4");

    a_r7_branch_taken: assert property (@(posedge clk) disable iff (rst)
        ((imem_rdata[31:26] == OPC_BREQ) && (rs_val == rt_val)) |=>
        (imem_addr == $past(imem_addr) + 32'd4 + branch_disp($past(imem_rdata[15:0]))))
        else $error("R7 taken branch target wrong");

    a_r7_branch_not_taken: assert property (@(posedge clk) disable iff (rst)
        ((imem_rdata[31:26] == OPC_BREQ) && (rs_val != rt_val)) |=>
        (imem_addr == $past(imem_addr) + 32'd4))
        else $error("R7 untaken branch moved PC");

    a_r6_store_strobe: assert property (@(posedge clk) disable iff (rst)
        dmem_we == (imem_rdata[31:26] == OPC_STORE))
        else $error("R6 write strobe does not match opcode");

    a_r6_store_data: assert property (@(posedge clk) disable iff (rst)
        (imem_rdata[31:26] == OPC_STORE) |-> (dmem_wdata == rt_val))
        else $error("R6 store data is not the rt register");

    a_r8_zero_reads: assert property (@(posedge clk) disable iff (rst)
        (imem_rdata[25:21] == 5'd0) |-> (rs_val == '0))
        else $error("R8 register zero read nonzero");

endmodule

bind lite_core lite_core_checker u_lite_core_checker (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_we    (dmem_we),
    .dmem_wdata (dmem_wdata),
    .rs_val     (rs_val),
    .rt_val     (rt_val)
);

// File: tb/lite_core_bench.sv
module lite_core_bench;

    localparam int CLK_HALF   = 5;
    localparam int WD_CYCLES  = 100000;
    localparam int RAND_RUNS  = 4;
    localparam int RAND_LEN   = 2000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [256];

    // Reference state
    logic [31:0] rr   [32];
    logic [31:0] rmem [256];
    logic [31:0] rpc = 32'd0;
    string       last_tag = "R1";

    logic [31:0] st_addr [16];
    logic [31:0] st_data [16];
    int          st_n = 0;
    bit          chk_en = 1'b0;
    bit          done = 1'b0;
    int          n_tests = 0;
    int          n_fail = 0;
    logic [31:0] seed;

    always #(CLK_HALF) clk = ~clk;

    lite_core u_lite_core (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[9:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;
    end

    function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                          input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] sx(input logic [15:0] imm);
        return {{16{imm[15]}}, imm};
    endfunction

    function automatic logic [31:0] xs_next(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    function automatic logic [31:0] gen_instr(input logic [31:0] r);
        logic [4:0] rs, rt, rd;
        logic [5:0] x;
        rs = {2'b00, r[5:3]};
        rt = {2'b00, r[8:6]};
        rd = {2'b00, r[11:9]};
        x  = r[31:26];
        case (r[2:0])
            3'd0: return enc_r(rs, rt, rd, 6'h21);
            3'd1: return enc_r(rs, rt, rd, 6'h23);
            3'd2: return enc_i(6'h0D, rs, rt, r[31:16]);
            3'd3: return enc_i(6'h23, rs, rt, r[31:16]);
            3'd4: return enc_i(6'h2B, rs, rt, r[31:16]);
            3'd5: return enc_i(6'h04, rs, rt, {{13{r[20]}}, r[20:18]});
            3'd6: begin
                if (x == 6'h00 || x == 6'h0D || x == 6'h23 || x == 6'h2B || x == 6'h04)
                    x = 6'h3F;
                return enc_i(x, rs, rt, r[27:12]);
            end
            default: begin
                if (x == 6'h21 || x == 6'h23) x = 6'h00;
                return enc_r(rs, rt, rd, x);
            end
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic rwr(input logic [4:0] idx, input logic [31:0] val);
        if (idx != 5'd0) rr[idx] = val;   // R8: writes to register 0 vanish
    endtask

    // One reference instruction per cycle, compared at the falling edge.
    task automatic step();
        logic [31:0] ins, a, b, ea, nxt;
        logic [5:0]  op, fn;
        logic [4:0]  rs, rt, rd;
        logic [15:0] imm;
        string       tag;
        ins = imem[rpc[7:2]];
        op  = ins[31:26];
        rs  = ins[25:21];
        rt  = ins[20:16];
        rd  = ins[15:11];
        fn  = ins[5:0];
        imm = ins[15:0];
        a   = (rs == 5'd0) ? 32'd0 : rr[rs];
        b   = (rt == 5'd0) ? 32'd0 : rr[rt];
        ea  = a + sx(imm);
        chk({last_tag, " fetch address"}, imem_addr, rpc);
        if (dmem_we && st_n < 16) begin
            st_addr[st_n] = dmem_addr;
            st_data[st_n] = dmem_wdata;
            st_n++;
        end
        nxt = rpc + 32'd4;
        if (rst) begin
            chk("R1 write strobe in reset", {31'd0, dmem_we}, 32'd0);
            nxt = 32'd0;
            tag = "R1";
        end else begin
            tag = "R9";
            case (op)
                6'h00: begin
                    if (fn == 6'h21) begin
                        tag = "R2"; rwr(rd, a + b);
                    end else if (fn == 6'h23) begin
                        tag = "R3"; rwr(rd, a - b);
                    end
                end
                6'h0D: begin
                    tag = "R4"; rwr(rt, a | {16'h0, imm});
                end
                6'h23: begin
                    tag = "R5";
                    chk("R5 load address", dmem_addr, ea);
                    rwr(rt, rmem[ea[9:2]]);
                end
                6'h2B: begin
                    tag = "R6";
                    chk("R6 store strobe", {31'd0, dmem_we}, 32'd1);
                    chk("R6 store address", dmem_addr, ea);
                    chk("R6 store data", dmem_wdata, b);
                    rmem[ea[9:2]] = b;
                end
                6'h04: begin
                    tag = "R7";
                    if (a == b) nxt = rpc + 32'd4 + {sx(imm)[29:0], 2'b00};
                end
                default: ;
            endcase
            if (op != 6'h2B) chk({tag, " no store strobe"}, {31'd0, dmem_we}, 32'd0);
        end
        last_tag = tag;
        rpc = nxt;
    endtask

    always @(negedge clk) begin
        if (chk_en) step();
    end

    initial begin
        for (int i = 0; i < 32; i++) rr[i] = 32'd0;
        for (int i = 0; i < 256; i++) begin
            dmem[i] = 32'd0;
            rmem[i] = 32'd0;
        end
        for (int i = 0; i < 64; i++) imem[i] = 32'd0;
        // Directed program
        imem[0]  = enc_i(6'h2B, 5'd0, 5'd0, 16'h0030);   // store, blocked while in reset
        imem[1]  = enc_i(6'h0D, 5'd0, 5'd1, 16'h8001);
        imem[2]  = enc_i(6'h0D, 5'd0, 5'd2, 16'h0003);
        imem[3]  = enc_r(5'd1, 5'd2, 5'd3, 6'h21);
        imem[4]  = enc_r(5'd2, 5'd1, 5'd4, 6'h23);
        imem[5]  = enc_i(6'h2B, 5'd0, 5'd3, 16'h0010);
        imem[6]  = enc_i(6'h2B, 5'd2, 5'd4, 16'hFFFC);
        imem[7]  = enc_r(5'd1, 5'd2, 5'd0, 6'h21);
        imem[8]  = enc_i(6'h2B, 5'd0, 5'd0, 16'h0020);
        imem[9]  = enc_i(6'h23, 5'd0, 5'd5, 16'h0010);
        imem[10] = enc_i(6'h2B, 5'd0, 5'd5, 16'h0024);
        imem[11] = enc_r(5'd1, 5'd1, 5'd1, 6'h21);
        imem[12] = enc_i(6'h2B, 5'd0, 5'd1, 16'h0028);
        imem[13] = enc_i(6'h04, 5'd2, 5'd2, 16'h0002);
        imem[14] = enc_i(6'h0D, 5'd0, 5'd2, 16'h7777);
        imem[15] = enc_i(6'h0D, 5'd0, 5'd2, 16'h7777);
        imem[16] = enc_i(6'h04, 5'd1, 5'd2, 16'h0005);
        imem[17] = enc_i(6'h3F, 5'd1, 5'd2, 16'h1234);
        imem[18] = enc_r(5'd1, 5'd1, 5'd2, 6'h20);
        imem[19] = enc_i(6'h2B, 5'd0, 5'd2, 16'h002C);
        imem[20] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);

        @(posedge clk);
        #1 chk_en = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        repeat (40) @(posedge clk);
        #1;
        chk("R7 backward branch holds PC", imem_addr, 32'd80);
        chk("R6 store count", st_n, 32'd7);
        chk("R6 first store address", st_addr[0], 32'h30);
        chk("R8 register zero stores zero", st_data[0], 32'h0);
        chk("R2 sum stored", st_data[1], 32'h0000_8004);
        chk("R4 literal zero-extended", st_addr[1], 32'h10);
        chk("R3 difference stored", st_data[2], 32'hFFFF_8002);
        chk("R5 negative offset address", st_addr[2], 32'hFFFF_FFFF);
        chk("R8 write to register zero dropped", st_data[3], 32'h0);
        chk("R5 loaded word", st_data[4], 32'h0000_8004);
        chk("R10 self-referencing add", st_data[5], 32'h0001_0002);
        chk("R9 R7 register untouched", st_data[6], 32'h3);

        // Random streams over registers 0..7
        seed = 32'h1D2C_3B4A;
        for (int run = 0; run < RAND_RUNS; run++) begin
            rst = 1'b1;
            repeat (2) @(posedge clk);
            #1;
            for (int w = 0; w < 64; w++) begin
                seed = xs_next(seed);
                if (w >= 1 && w <= 7)
                    imem[w] = enc_i(6'h0D, 5'd0, w[4:0], seed[15:0]);
                else
                    imem[w] = gen_instr(seed);
            end
            chk("R1 PC held at zero in reset", imem_addr, 32'd0);
            rst = 1'b0;
            repeat (RAND_LEN) @(posedge clk);
            #1;
        end
        chk_en = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(WD_CYCLES * 2 * CLK_HALF);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (R1..R10 run incomplete): actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule